// File: doc/BRIEF.md
# Dual-Clock Memory Request Bridge

This block moves read and write requests from a slow user clock domain into a faster, unrelated memory-controller clock domain, and carries each result back. On the user side, a request is pushed into a request queue that crosses clock domains. A request holds a direction bit, an address and write data. In the controller domain, an engine takes one entry off the queue and presents it as a command for one cycle. It then waits for the controller's done strobe and places the result into a second queue that crosses back to the user domain.

A user-side stage takes each result off the response queue. For a read it loads the returned data into an output register, and in every case it signals completion with a one-cycle pulse. Only one request may be in flight at a time: a busy flag covers the span from acceptance to completion. Each queue is a small asynchronous FIFO with Gray-coded pointers and two-flop synchronizers. Each clock domain has its own asynchronous active-low reset, which is released synchronously to that domain's clock.

Top module: `mem_req_bridge`

## Requirements
- R1: After both resets, `usr_busy`, `usr_done`, `usr_done_we` and `mem_cmd_valid` are 0 and `usr_rdata` is all zeros.
- R2: A request on `usr_req` while not busy is accepted at that user clock edge, and `usr_busy` reads 1 in the following cycle. Exactly one command then reaches the controller port. It carries the same direction, address and write data, where direction 1 means write and 0 means read.
- R3: `mem_cmd_valid` is high for exactly one controller clock cycle per accepted request.
- R4: Completion is reported only after the controller's `mem_done` for that command. It is reported as a one-cycle `usr_done` pulse, and `usr_busy` falls in that same cycle.
- R5: When a read completes, `usr_rdata` holds the `mem_rdata` value sampled with `mem_done`, and `usr_done_we` is 0.
- R6: When a write completes, `usr_rdata` keeps its previous value, and `usr_done_we` is 1.
- R7: A request raised while `usr_busy` is 1 is dropped. It produces no controller command, and `usr_busy` stays 1 until the pending request completes.
- R8: A `mem_done` pulse while no command is outstanding is ignored. It produces no completion, and later requests complete normally.
- R9: Requests issued back to back, each one in the cycle after the previous completion, all complete in order without stalling.
- R10: The controller-side engine removes a request entry only when the request queue is non-empty. It inserts a response only when the response queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_usr | input | 1 | User-domain clock |
| rst_usr_n | input | 1 | User-domain asynchronous reset, active low |
| clk_mem | input | 1 | Controller-domain clock |
| rst_mem_n | input | 1 | Controller-domain asynchronous reset, active low |
| usr_req | input | 1 | Request strobe, one user cycle |
| usr_we | input | 1 | Request direction: 1 write, 0 read |
| usr_addr | input | ADDR_W | Request address |
| usr_wdata | input | DATA_W | Request write data |
| usr_busy | output | 1 | A request is in flight |
| usr_done | output | 1 | One-cycle completion pulse |
| usr_done_we | output | 1 | Direction of the request just completed |
| usr_rdata | output | DATA_W | Data returned by the last completed read |
| mem_cmd_valid | output | 1 | Command strobe to the controller, one cycle |
| mem_cmd_we | output | 1 | Command direction: 1 write, 0 read |
| mem_cmd_addr | output | ADDR_W | Command address |
| mem_cmd_wdata | output | DATA_W | Command write data |
| mem_done | input | 1 | Controller completion strobe |
| mem_rdata | input | DATA_W | Read data, valid with mem_done |

## Verification
The bench builds the bridge with its default widths: a 28-bit address, 32-bit data and four-entry queues. It runs a 20 ns user clock against a 7 ns controller clock, so pointer crossings land at many different phases between the two domains. Addresses are folded onto 16 words, so random reads often return data written earlier, and a lost or misdirected write shows up in a later read. The bench also varies the controller's done latency. A request raised in the cycle right after acceptance tests the one-in-flight rule, and a stray done strobe while idle tests the engine's waiting state.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_ISSUE = 2'd1,
    ENG_WAIT  = 2'd2,
    ENG_RESP  = 2'd3
  } eng_state_t;

  localparam logic OP_READ  = 1'b0;
  localparam logic OP_WRITE = 1'b1;
endpackage

// File: rtl/mrb_rst_sync.sv
module mrb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n = stg_q[1];
endmodule

// File: rtl/mrb_sync.sv
module mrb_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/mrb_afifo.sv
module mrb_afifo #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] TOP2 = {2'b11, {(AW-1){1'b0}}};

  logic [W-1:0] store [DEPTH];

  logic [AW:0] wbin_q, wbin_d, wgray_q, wgray_d, rgray_at_w;
  logic [AW:0] rbin_q, rbin_d, rgray_q, rgray_d, wgray_at_r;
  logic        wpush, rpop, full_d, empty_d;

  // write domain
  assign wpush   = wr_en & ~full;
  assign wbin_d  = wbin_q + {{AW{1'b0}}, wpush};
  assign wgray_d = wbin_d ^ (wbin_d >> 1);
  assign full_d  = (wgray_d == (rgray_at_w ^ TOP2));

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full    <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      full    <= full_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (wpush) store[wbin_q[AW-1:0]] <= wdata;
  end

  mrb_sync #(.W(AW+1)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_at_w)
  );

  // read domain
  assign rpop    = rd_en & ~empty;
  assign rbin_d  = rbin_q + {{AW{1'b0}}, rpop};
  assign rgray_d = rbin_d ^ (rbin_d >> 1);
  assign empty_d = (rgray_d == wgray_at_r);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty   <= 1'b1;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      empty   <= empty_d;
    end
  end

  mrb_sync #(.W(AW+1)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_at_r)
  );

  assign rdata = store[rbin_q[AW-1:0]];
endmodule

// File: rtl/mrb_engine.sv
module mrb_engine
  import mrb_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  localparam int REQ_W = 1 + ADDR_W + DATA_W,
  localparam int RSP_W = 1 + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_empty,
  input  logic [REQ_W-1:0]  req_data,
  output logic              req_pop,
  input  logic              resp_full,
  output logic              resp_push,
  output logic [RSP_W-1:0]  resp_data,
  output logic              cmd_valid,
  output logic              cmd_we,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              done,
  input  logic [DATA_W-1:0] rdata_in
);
  eng_state_t        state_q, state_d;
  logic              op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_q;
  logic              take_done;

  always_comb begin
    state_d   = state_q;
    req_pop   = 1'b0;
    resp_push = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (!req_empty) begin
          req_pop = 1'b1;
          state_d = ENG_ISSUE;
        end
      end
      ENG_ISSUE: state_d = ENG_WAIT;
      ENG_WAIT: begin
        if (done) state_d = ENG_RESP;
      end
      ENG_RESP: begin
        if (!resp_full) begin
          resp_push = 1'b1;
          state_d   = ENG_IDLE;
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  assign take_done = (state_q == ENG_WAIT) & done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ENG_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_READ;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      if (req_pop) {op_q, addr_q, wdata_q} <= req_data;
      if (take_done) rd_q <= (op_q == OP_WRITE) ? '0 : rdata_in;
    end
  end

  assign cmd_valid = (state_q == ENG_ISSUE);
  assign cmd_we    = op_q;
  assign cmd_addr  = addr_q;
  assign cmd_wdata = wdata_q;
  assign resp_data = {op_q, rd_q};
endmodule

// File: rtl/mrb_user.sv
module mrb_user
  import mrb_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  localparam int REQ_W = 1 + ADDR_W + DATA_W,
  localparam int RSP_W = 1 + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              req_full,
  output logic              req_push,
  output logic [REQ_W-1:0]  req_data,
  input  logic              resp_empty,
  input  logic [RSP_W-1:0]  resp_data,
  output logic              resp_pop,
  output logic              busy,
  output logic              done,
  output logic              done_we,
  output logic [DATA_W-1:0] rdata
);
  logic busy_d;
  logic load_rd;

  assign req_push = req & ~busy & ~req_full;
  assign req_data = {we, addr, wdata};
  assign resp_pop = ~resp_empty;
  assign load_rd  = resp_pop & (resp_data[DATA_W] == OP_READ);

  always_comb begin
    busy_d = busy;
    if (resp_pop)      busy_d = 1'b0;
    else if (req_push) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      done_we <= 1'b0;
      rdata   <= '0;
    end else begin
      busy <= busy_d;
      done <= resp_pop;
      if (resp_pop) done_we <= resp_data[DATA_W];
      if (load_rd)  rdata   <= resp_data[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/mem_req_bridge.sv
module mem_req_bridge
  import mrb_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int DATA_W  = 32,
  parameter int FIFO_AW = 2
) (
  input  logic              clk_usr,
  input  logic              rst_usr_n,
  input  logic              clk_mem,
  input  logic              rst_mem_n,
  input  logic              usr_req,
  input  logic              usr_we,
  input  logic [ADDR_W-1:0] usr_addr,
  input  logic [DATA_W-1:0] usr_wdata,
  output logic              usr_busy,
  output logic              usr_done,
  output logic              usr_done_we,
  output logic [DATA_W-1:0] usr_rdata,
  output logic              mem_cmd_valid,
  output logic              mem_cmd_we,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic [DATA_W-1:0] mem_cmd_wdata,
  input  logic              mem_done,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int REQ_W = 1 + ADDR_W + DATA_W;
  localparam int RSP_W = 1 + DATA_W;

  logic             usr_rst_n, mem_rst_n;
  logic             req_push, req_full, req_pop, req_empty;
  logic [REQ_W-1:0] req_wdata, req_rdata;
  logic             resp_push, resp_full, resp_pop, resp_empty;
  logic [RSP_W-1:0] resp_wdata, resp_rdata;

  mrb_rst_sync u_rst_usr (.clk(clk_usr), .arst_n(rst_usr_n), .rst_n(usr_rst_n));
  mrb_rst_sync u_rst_mem (.clk(clk_mem), .arst_n(rst_mem_n), .rst_n(mem_rst_n));

  mrb_user #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_user (
    .clk(clk_usr), .rst_n(usr_rst_n),
    .req(usr_req), .we(usr_we), .addr(usr_addr), .wdata(usr_wdata),
    .req_full(req_full), .req_push(req_push), .req_data(req_wdata),
    .resp_empty(resp_empty), .resp_data(resp_rdata), .resp_pop(resp_pop),
    .busy(usr_busy), .done(usr_done), .done_we(usr_done_we), .rdata(usr_rdata)
  );

  mrb_afifo #(.W(REQ_W), .AW(FIFO_AW)) u_req_q (
    .wclk(clk_usr), .wrst_n(usr_rst_n), .wr_en(req_push), .wdata(req_wdata), .full(req_full),
    .rclk(clk_mem), .rrst_n(mem_rst_n), .rd_en(req_pop), .rdata(req_rdata), .empty(req_empty)
  );

  mrb_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk_mem), .rst_n(mem_rst_n),
    .req_empty(req_empty), .req_data(req_rdata), .req_pop(req_pop),
    .resp_full(resp_full), .resp_push(resp_push), .resp_data(resp_wdata),
    .cmd_valid(mem_cmd_valid), .cmd_we(mem_cmd_we), .cmd_addr(mem_cmd_addr),
    .cmd_wdata(mem_cmd_wdata), .done(mem_done), .rdata_in(mem_rdata)
  );

  mrb_afifo #(.W(RSP_W), .AW(FIFO_AW)) u_rsp_q (
    .wclk(clk_mem), .wrst_n(mem_rst_n), .wr_en(resp_push), .wdata(resp_wdata), .full(resp_full),
    .rclk(clk_usr), .rrst_n(usr_rst_n), .rd_en(resp_pop), .rdata(resp_rdata), .empty(resp_empty)
  );
endmodule

// File: rtl/mem_req_bridge_chk.sv
module mem_req_bridge_chk (
  input logic clk_usr,
  input logic rst_usr_n,
  input logic clk_mem,
  input logic rst_mem_n,
  input logic usr_busy,
  input logic usr_done,
  input logic mem_cmd_valid,
  input logic req_pop,
  input logic req_empty,
  input logic resp_push,
  input logic resp_full
);
  // R3
  cmd_pulse_chk: assert property (@(posedge clk_mem) disable iff (!rst_mem_n)
    mem_cmd_valid |=> !mem_cmd_valid);

  // R4
  done_clears_busy_chk: assert property (@(posedge clk_usr) disable iff (!rst_usr_n)
    usr_done |-> !usr_busy);

  // R4
  done_needs_busy_chk: assert property (@(posedge clk_usr) disable iff (!rst_usr_n)
    usr_done |-> $past(usr_busy));

  // R7
  busy_fall_chk: assert property (@(posedge clk_usr) disable iff (!rst_usr_n)
    $fell(usr_busy) |-> usr_done);

  // R10
  req_pop_chk: assert property (@(posedge clk_mem) disable iff (!rst_mem_n)
    req_pop |-> !req_empty);

  // R10
  resp_push_chk: assert property (@(posedge clk_mem) disable iff (!rst_mem_n)
    resp_push |-> !resp_full);
endmodule

bind mem_req_bridge mem_req_bridge_chk u_chk (
  .clk_usr(clk_usr), .rst_usr_n(rst_usr_n), .clk_mem(clk_mem), .rst_mem_n(rst_mem_n),
  .usr_busy(usr_busy), .usr_done(usr_done), .mem_cmd_valid(mem_cmd_valid),
  .req_pop(req_pop), .req_empty(req_empty), .resp_push(resp_push), .resp_full(resp_full)
);

// File: tb/tb_mem_req_bridge.sv
module tb_mem_req_bridge;
  localparam int  ADDR_W     = 28;
  localparam int  DATA_W     = 32;
  localparam time USR_PERIOD = 20ns;
  localparam time MEM_PERIOD = 7ns;
  localparam int  WDOG_LIMIT = 150000;

  logic              clk_usr = 1'b0, clk_mem = 1'b0;
  logic              rst_usr_n = 1'b0, rst_mem_n = 1'b0;
  logic              usr_req = 1'b0, usr_we = 1'b0;
  logic [ADDR_W-1:0] usr_addr = '0;
  logic [DATA_W-1:0] usr_wdata = '0;
  logic              usr_busy, usr_done, usr_done_we;
  logic [DATA_W-1:0] usr_rdata;
  logic              mem_cmd_valid, mem_cmd_we;
  logic [ADDR_W-1:0] mem_cmd_addr;
  logic [DATA_W-1:0] mem_cmd_wdata;
  logic              mem_done = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  always #(USR_PERIOD/2) clk_usr = ~clk_usr;
  always #(MEM_PERIOD/2) clk_mem = ~clk_mem;

  mem_req_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_AW(2)) dut (
    .clk_usr(clk_usr), .rst_usr_n(rst_usr_n), .clk_mem(clk_mem), .rst_mem_n(rst_mem_n),
    .usr_req(usr_req), .usr_we(usr_we), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
    .usr_busy(usr_busy), .usr_done(usr_done), .usr_done_we(usr_done_we), .usr_rdata(usr_rdata),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_we(mem_cmd_we), .mem_cmd_addr(mem_cmd_addr),
    .mem_cmd_wdata(mem_cmd_wdata), .mem_done(mem_done), .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0;
  int cmd_count = 0, done_seen = 0;
  bit stray_req = 1'b0;
  logic              exp_we;
  logic [ADDR_W-1:0] exp_addr;
  logic [DATA_W-1:0] exp_wdata;
  logic [DATA_W-1:0] model_mem [16];
  logic [DATA_W-1:0] shadow    [16];

  function automatic logic [DATA_W-1:0] seed_word(input int i);
    return 32'hC0DE_0000 ^ (i * 32'h0101_0101);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // controller model, driven on falling edges of clk_mem
  initial begin
    for (int i = 0; i < 16; i++) model_mem[i] = seed_word(i);
    forever begin
      @(negedge clk_mem);
      if (mem_cmd_valid === 1'b1) begin
        cmd_count++;
        check(mem_cmd_we == exp_we && mem_cmd_addr == exp_addr &&
              (exp_we == 1'b0 || mem_cmd_wdata == exp_wdata),
              "R2", "command fields", {mem_cmd_we, mem_cmd_addr}, {exp_we, exp_addr});
        repeat ($urandom_range(0, 3)) @(negedge clk_mem);
        @(negedge clk_mem);
        if (mem_cmd_we) begin
          model_mem[mem_cmd_addr[3:0]] = mem_cmd_wdata;
          mem_rdata = $urandom();
        end else begin
          mem_rdata = model_mem[mem_cmd_addr[3:0]];
        end
        mem_done = 1'b1;
        @(negedge clk_mem);
        mem_done = 1'b0;
      end else if (stray_req) begin
        mem_rdata = 32'hDEAD_BEEF;
        mem_done  = 1'b1;
        @(negedge clk_mem);
        mem_done  = 1'b0;
        stray_req = 1'b0;
      end
    end
  end

  always @(negedge clk_usr) if (usr_done === 1'b1) done_seen++;

  task automatic do_txn(input logic we, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input bit poke, input string tag);
    logic [DATA_W-1:0] prev_rd;
    int                cmds_before;
    bit                got;
    @(negedge clk_usr);
    while (usr_busy) @(negedge clk_usr);
    prev_rd     = usr_rdata;
    cmds_before = cmd_count;
    exp_we = we; exp_addr = a; exp_wdata = d;
    usr_req = 1'b1; usr_we = we; usr_addr = a; usr_wdata = d;
    @(negedge clk_usr);
    usr_req = 1'b0;
    check(usr_busy === 1'b1, "R2", {tag, " busy after accept"}, usr_busy, 1);
    got = usr_done;
    if (poke && !got) begin
      // R7: second request while busy
      usr_req = 1'b1; usr_we = ~we; usr_addr = a ^ 28'h5; usr_wdata = ~d;
      @(negedge clk_usr);
      usr_req = 1'b0;
      got = usr_done;
    end
    for (int k = 0; k < 400 && !got; k++) begin
      @(negedge clk_usr);
      got = usr_done;
    end
    check(got, "R9", {tag, " completion seen"}, got, 1);
    if (got) begin
      check(usr_busy === 1'b0, "R4", {tag, " busy clear with done"}, usr_busy, 0);
      check(usr_done_we === we, we ? "R6" : "R5", {tag, " done direction"}, usr_done_we, we);
      if (we) begin
        check(usr_rdata === prev_rd, "R6", {tag, " rdata kept on write"}, usr_rdata, prev_rd);
        shadow[a[3:0]] = d;
      end else begin
        check(usr_rdata === shadow[a[3:0]], "R5", {tag, " read data"}, usr_rdata, shadow[a[3:0]]);
      end
      check(cmd_count == cmds_before + 1, poke ? "R7" : "R2", {tag, " one command"},
            cmd_count, cmds_before + 1);
      @(negedge clk_usr);
      check(usr_done === 1'b0, "R4", {tag, " done one cycle"}, usr_done, 0);
    end
  endtask

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk_usr);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG_LIMIT, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0, c0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) shadow[i] = seed_word(i);
    repeat (4) @(negedge clk_usr);
    rst_usr_n = 1'b1;
    rst_mem_n = 1'b1;
    repeat (5) @(negedge clk_usr);
    check(usr_busy === 1'b0 && usr_done === 1'b0 && usr_done_we === 1'b0,
          "R1", "user flags after reset", {usr_busy, usr_done, usr_done_we}, 0);
    check(usr_rdata === '0, "R1", "rdata after reset", usr_rdata, 0);
    check(mem_cmd_valid === 1'b0 && cmd_count == 0, "R1", "no command after reset",
          mem_cmd_valid, 0);

    // directed: read of seeded word, then write and read-back
    do_txn(1'b0, 28'h000_0003, '0, 1'b0, "R5 first read");
    do_txn(1'b1, 28'h123_4563, 32'h1357_9BDF, 1'b0, "R6 write");
    do_txn(1'b0, 28'h000_0003, '0, 1'b0, "R2 read back");
    // R7: requests raised while busy
    do_txn(1'b1, 28'h0AB_CDE7, 32'hFEED_F00D, 1'b1, "R7 poke on write");
    do_txn(1'b0, 28'h0AB_CDE7, '0, 1'b1, "R7 poke on read");
    do_txn(1'b0, 28'h0AB_CDE2, '0, 1'b0, "R7 poked address untouched");

    // R8: stray done while idle
    @(negedge clk_usr);
    d0 = done_seen; c0 = cmd_count;
    stray_req = 1'b1;
    repeat (30) @(negedge clk_usr);
    check(done_seen == d0, "R8", "no completion from stray done", done_seen, d0);
    check(usr_busy === 1'b0 && cmd_count == c0, "R8", "idle after stray done",
          {usr_busy, 32'(cmd_count)}, {1'b0, 32'(c0)});
    do_txn(1'b0, 28'h000_0009, '0, 1'b0, "R8 read after stray");

    // R9: back-to-back random traffic
    for (int n = 0; n < 60; n++) begin
      logic              w;
      logic [ADDR_W-1:0] a;
      w = 1'($urandom_range(0, 1));
      a = ADDR_W'($urandom());
      do_txn(w, a, $urandom(), ($urandom_range(0, 3) == 0), "R9 random");
    end

    repeat (4) @(negedge clk_usr);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule